// File: doc/BRIEF.md
# Nibble-to-Byte LCD Bus Adapter

This block joins a display controller that drives pixel data four bits at a time to a panel that takes eight bits at a time. It takes each pair of nibbles that arrive on consecutive rising edges of the incoming shift clock and merges them into one byte. The first nibble of a pair becomes the low half and the second nibble becomes the high half. It also produces a panel shift clock at half the incoming rate.

The whole block runs on one system clock that is fast enough to oversample the controller strobes. The incoming shift clock and line strobe each pass through a two-flop synchronizer, and a rising-edge detector follows each synchronizer. The incoming nibble goes through a delay line of the same depth, so each detected edge is paired with the nibble that was present when that edge was sampled. A rising line strobe puts the halved clock back to its low level and restarts pairing, so every line begins with a first nibble. The frame strobe, AC-bias, enable and line strobe reach the panel unchanged. Refresh rate and colour depth are therefore not affected.

Top module: `nibble_byte_adapter`

## Requirements
- R1: While reset is asserted and just after it is released, the panel shift clock output and the 8-bit data output are both 0.
- R2: Each rising edge of the incoming shift clock inverts the panel shift clock, so the panel clock runs at half the incoming rate. The change appears on the third system clock edge that samples the incoming clock high.
- R3: Within a pair, the first nibble goes to data bits 3:0 and the second nibble goes to bits 7:4. Both halves appear on the output together, on the edge that completes the pair.
- R4: A rising edge that carries the first nibble of a pair leaves the 8-bit data output unchanged.
- R5: A rising edge of the line strobe forces the panel shift clock low. The next incoming shift clock edge after it is then treated as the first nibble of a new pair, even if the previous line ended with an unpaired nibble.
- R6: When rising edges of the line strobe and the incoming shift clock are detected in the same system cycle, the line strobe wins. The panel clock goes low, the data output is unchanged, and pairing restarts.
- R7: The line strobe, frame strobe, AC-bias and enable outputs follow their inputs combinationally, in the same cycle.
- R8: The following do not change the panel shift clock or the data output: falling edges of the incoming shift clock, holding it at a steady level, and changing the nibble while no rising edge occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the strobes |
| rst_n | input | 1 | Asynchronous reset, active low |
| nib_i | input | 4 | Nibble data from the controller |
| sclk_i | input | 1 | Incoming shift clock |
| lstb_i | input | 1 | Incoming line strobe |
| fstb_i | input | 1 | Incoming frame strobe |
| bias_i | input | 1 | Incoming AC-bias signal |
| en_i | input | 1 | Incoming display enable |
| byte_o | output | 8 | Paired byte to the panel |
| sclk_o | output | 1 | Half-rate panel shift clock |
| lstb_o | output | 1 | Line strobe to the panel |
| fstb_o | output | 1 | Frame strobe to the panel |
| bias_o | output | 1 | AC-bias to the panel |
| en_o | output | 1 | Enable to the panel |

## Verification
A rising edge on the incoming shift clock or line strobe produces a registered result three system clock edges after the first edge that samples it. That latency is two synchronizer flops plus the state register. The bench applies each strobe on a falling system edge and holds it for four cycles before checking. It then holds the strobe low for four more cycles, so each result is read after it has settled and before the next strobe can act. The pass-through outputs carry no latency, so they are checked one time step after their inputs are driven.

// File: rtl/nbp_pkg.sv
package nbp_pkg;
  localparam int NIB_W   = 4;
  localparam int BYTE_W  = 2 * NIB_W;
  localparam int SYNC_N  = 2;

  function automatic logic [BYTE_W-1:0] join_pair(input logic [NIB_W-1:0] lo,
                                                   input logic [NIB_W-1:0] hi);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/nbp_edge_sync.sv
module nbp_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sh;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      last_q <= 1'b0;
    end else begin
      sh     <= {sh[STAGES-2:0], async_i};
      last_q <= sh[STAGES-1];
    end
  end

  assign rise_o = sh[STAGES-1] & ~last_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R8
endmodule

// File: rtl/nbp_half_div.sv
module nbp_half_div (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  input  logic clear_i,
  output logic half_o
);
  logic half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       half_q <= 1'b0;
    else if (clear_i) half_q <= 1'b0;
    else if (step_i)  half_q <= ~half_q;
  end

  assign half_o = half_q;

  AST_HALF_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clear_i) |=> (half_o != $past(half_o))); // R2
  AST_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !half_o); // R5
  AST_HALF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !clear_i) |=> $stable(half_o)); // R8
endmodule

// File: rtl/nbp_packer.sv
module nbp_packer
  import nbp_pkg::*;
#(
  parameter int STAGES = SYNC_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIB_W-1:0]  nib_i,
  input  logic              step_i,
  input  logic              clear_i,
  output logic [BYTE_W-1:0] byte_o
);
  logic [NIB_W-1:0]  dpipe [STAGES];
  logic [NIB_W-1:0]  lo_q;
  logic [BYTE_W-1:0] byte_q;
  logic              second_q;
  logic              take_first;
  logic              complete;

  for (genvar g = 0; g < STAGES; g++) begin : g_dly
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dpipe[g] <= '0;
      else if (g == 0) dpipe[g] <= nib_i;
      else             dpipe[g] <= dpipe[(g == 0) ? 0 : g-1];
    end
  end

  assign take_first = step_i & ~clear_i & ~second_q;
  assign complete   = step_i & ~clear_i &  second_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q     <= '0;
      byte_q   <= '0;
      second_q <= 1'b0;
    end else if (clear_i) begin
      second_q <= 1'b0;
    end else if (take_first) begin
      lo_q     <= dpipe[STAGES-1];
      second_q <= 1'b1;
    end else if (complete) begin
      byte_q   <= join_pair(lo_q, dpipe[STAGES-1]);
      second_q <= 1'b0;
    end
  end

  assign byte_o = byte_q;

  AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !complete |=> $stable(byte_o)); // R4
  AST_PAIR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !second_q); // R5
  AST_HIGH_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    complete |=> (byte_o[BYTE_W-1:NIB_W] == $past(dpipe[STAGES-1]))); // R3
endmodule

// File: rtl/nibble_byte_adapter.sv
module nibble_byte_adapter
  import nbp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIB_W-1:0]  nib_i,
  input  logic              sclk_i,
  input  logic              lstb_i,
  input  logic              fstb_i,
  input  logic              bias_i,
  input  logic              en_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              sclk_o,
  output logic              lstb_o,
  output logic              fstb_o,
  output logic              bias_o,
  output logic              en_o
);
  logic shift_rise;
  logic line_rise;

  nbp_edge_sync #(.STAGES(SYNC_N)) u_sync_shift (
    .clk(clk), .rst_n(rst_n), .async_i(sclk_i), .rise_o(shift_rise));

  nbp_edge_sync #(.STAGES(SYNC_N)) u_sync_line (
    .clk(clk), .rst_n(rst_n), .async_i(lstb_i), .rise_o(line_rise));

  nbp_half_div u_div (
    .clk(clk), .rst_n(rst_n), .step_i(shift_rise), .clear_i(line_rise),
    .half_o(sclk_o));

  nbp_packer #(.STAGES(SYNC_N)) u_pack (
    .clk(clk), .rst_n(rst_n), .nib_i(nib_i), .step_i(shift_rise),
    .clear_i(line_rise), .byte_o(byte_o));

  assign lstb_o = lstb_i;
  assign fstb_o = fstb_i;
  assign bias_o = bias_i;
  assign en_o   = en_i;

  AST_PAIR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(byte_o) |-> $fell(sclk_o)); // R3
endmodule

// File: tb/nibble_byte_adapter_tb_top.sv
module nibble_byte_adapter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] nib = '0;
  logic       sclk = 1'b0, lstb = 1'b0, fstb = 1'b0, bias = 1'b0, en = 1'b0;
  logic [7:0] byte_w;
  logic       sclk_w, lstb_w, fstb_w, bias_w, en_w;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  logic       m_sclk, m_second;
  logic [3:0] m_lo;
  logic [7:0] m_byte;

  always #4 clk = ~clk;

  nibble_byte_adapter dut_i (
    .clk(clk), .rst_n(rst_n), .nib_i(nib), .sclk_i(sclk), .lstb_i(lstb),
    .fstb_i(fstb), .bias_i(bias), .en_i(en), .byte_o(byte_w), .sclk_o(sclk_w),
    .lstb_o(lstb_w), .fstb_o(fstb_w), .bias_o(bias_w), .en_o(en_w));

  // entry: {starts a new line, nibble}
  localparam logic [4:0] VEC [12] = '{
    5'h13, 5'h0A, 5'h05, 5'h0C, 5'h0F, 5'h11,
    5'h02, 5'h07, 5'h19, 5'h04, 5'h00, 5'h0E};

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic line_pulse();
    lstb = 1'b1; wait_n(4);
    lstb = 1'b0; wait_n(4);
    m_sclk = 1'b0; m_second = 1'b0;
  endtask

  task automatic shift_pulse(logic [3:0] n);
    nib = n; sclk = 1'b1; wait_n(4);
    m_sclk = ~m_sclk;
    if (!m_second) begin m_lo = n; m_second = 1'b1; end
    else begin m_byte = 8'(n) * 8'd16 + 8'(m_lo); m_second = 1'b0; end
    sclk = 1'b0; wait_n(4);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected below 20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    m_sclk = 0; m_second = 0; m_lo = 0; m_byte = 0;
    wait_n(3);
    chk("R1 sclk in reset", sclk_w, 0);
    chk("R1 byte in reset", byte_w, 0);
    rst_n = 1'b1; wait_n(2);
    chk("R1 sclk after reset", sclk_w, 0);
    chk("R1 byte after reset", byte_w, 0);

    for (int i = 0; i < 12; i++) begin
      if (VEC[i][4]) begin
        line_pulse();
        chk("R5 line forces sclk low", sclk_w, 0);
      end
      shift_pulse(VEC[i][3:0]);
      chk("R2 half clock", sclk_w, m_sclk);
      chk("R3 R4 byte", byte_w, m_byte);
    end

    // R7 pass-through
    fstb = 1; bias = 0; en = 1; #1;
    chk("R7 fstb", fstb_w, 1); chk("R7 bias", bias_w, 0); chk("R7 en", en_w, 1);
    bias = 1; fstb = 0; lstb = 1; #1;
    chk("R7 bias", bias_w, 1); chk("R7 fstb", fstb_w, 0); chk("R7 lstb", lstb_w, 1);
    lstb = 0; en = 0; #1;
    chk("R7 lstb", lstb_w, 0); chk("R7 en", en_w, 0);
    wait_n(4);
    line_pulse();

    // R8 nibble change and long high level with no new edge
    shift_pulse(4'h6);
    nib = 4'h9; wait_n(6);
    chk("R8 nibble change no edge sclk", sclk_w, m_sclk);
    chk("R8 nibble change no edge byte", byte_w, m_byte);
    nib = 4'hB; sclk = 1; wait_n(4);
    m_sclk = ~m_sclk; m_byte = 8'hB6; m_second = 0;
    wait_n(20);
    chk("R8 held high sclk", sclk_w, m_sclk);
    chk("R3 pair byte", byte_w, 8'hB6);
    sclk = 0; wait_n(8);
    chk("R8 falling edge sclk", sclk_w, m_sclk);
    chk("R8 falling edge byte", byte_w, 8'hB6);

    // R6 simultaneous line and shift edges
    shift_pulse(4'h3);
    nib = 4'hD; sclk = 1; lstb = 1; wait_n(4);
    chk("R6 simultaneous sclk", sclk_w, 0);
    chk("R6 simultaneous byte", byte_w, 8'hB6);
    sclk = 0; lstb = 0; wait_n(4);
    m_sclk = 0; m_second = 0;
    shift_pulse(4'h8);
    chk("R6 byte after first", byte_w, 8'hB6);
    shift_pulse(4'h5);
    chk("R6 restarted pair", byte_w, 8'h58);
    chk("R6 sclk after pair", sclk_w, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule